// File: doc/BRIEF.md
# I2C-Programmed Two-Way Bus Selector Controller

This block is the digital half of a two-way I2C bus selector. It acts as an I2C target at a fixed 7-bit address and holds one 8-bit selection byte. From that byte it drives two enable outputs. Each enable would close the pass switch that joins the upstream clock/data pair to one of two downstream pairs. The block runs on a fast system clock and oversamples SCL and SDA through a synchroniser. It acknowledges and returns data by pulling SDA low through an open-drain output enable.

A host writes the selection byte with an ordinary write transfer and can read it back with a read transfer. A written byte takes effect on the enables only when the bus sees a STOP. The downstream lines are then idle high when a switch closes, so joining them cannot create a false START or STOP.

Top module: `i2csel_top`

## Requirements
- R1: At no time are both enable bits of `chan_en` high.
- R2: The applied byte decodes as follows: bit 2 low gives `chan_en`=00; bits[2:0]=100 gives `chan_en`=01 (channel 0 is bit 0); bits[2:0]=101 gives `chan_en`=10 (channel 1 is bit 1); bits[2:1]=11 gives 00; bits 7..3 have no effect.
- R3: After reset, the stored byte is 0x00, `chan_en` is 00 and `sda_oe` is 0.
- R4: A written byte reaches `chan_en` only after a STOP (SDA rising while SCL high). A repeated START does not apply it, and the earlier selection stays in force until then.
- R5: When several data bytes follow the address in one write, only the last byte received is kept.
- R6: Address byte bit 0 gives the direction (1 = read, 0 = write). A read returns the stored byte MSB first, repeated for each byte the host acknowledges.
- R7: An address byte whose upper 7 bits equal `ADDR`, and each data byte written after it, are acknowledged by `sda_oe`=1 during the ninth clock. `sda_oe` changes only while SCL is low.
- R8: During a read, when the host does not acknowledge a byte, `sda_oe` is 0 from then on, so the host can issue STOP.
- R9: After an address that does not match, the block gives no acknowledge and ignores further bytes until the next START or STOP. The stored byte and `chan_en` are left unchanged.
- R10: START is SDA falling while SCL is high. Any START, including one in mid-transfer, restarts address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, well above the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 = pull SDA low (open-drain) |
| chan_en | output | 2 | Downstream switch enables, bit 0 = channel 0 |

## Verification
The hardest state to reach is the window between a write's last acknowledge and the STOP. In that window the stored byte differs from the applied selection. A repeated START into a read can also fall there and must read back the new byte while the old selection still drives the enables. The bench sets this up deliberately: it writes a new value, checks the enables before the STOP, issues a repeated START and reads, checks again, and only then stops. Random multi-byte writes with random don't-care upper bits cover the decode table and the last-byte rule.

// File: rtl/i2csel_pkg.sv
// Package: shared types and the selection decode for the bus selector.
package i2csel_pkg;

    // Protocol engine states.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_AACK  = 3'd2,
        ST_WDATA = 3'd3,
        ST_WACK  = 3'd4,
        ST_RDATA = 3'd5,
        ST_RACK  = 3'd6,
        ST_SKIP  = 3'd7
    } eng_state_t;

    // Bit positions in the selection byte that the decode depends on.
    localparam int unsigned SEL_ON_BIT  = 2;
    localparam int unsigned SEL_BAD_BIT = 1;
    localparam int unsigned SEL_IDX_BIT = 0;

    // Turn a selection byte into a one-hot (or empty) enable pair.
    function automatic logic [1:0] sel_to_enable(input logic [7:0] sel);
        logic [1:0] en;
        en = 2'b00;
        if (sel[SEL_ON_BIT] && !sel[SEL_BAD_BIT])
            en[sel[SEL_IDX_BIT]] = 1'b1;
        return en;
    endfunction

endpackage

// File: rtl/i2csel_sync.sv
// Module: i2csel_sync
// Brings the raw SCL/SDA levels into the clock domain through a
// STAGES-deep flop chain and derives edge and bus-condition pulses.
// Assumes the system clock is many times faster than SCL, so every
// line level lasts several clocks.
module i2csel_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int unsigned LINES = 2;

    logic [LINES-1:0] raw_v;
    logic [LINES-1:0] chain_q [STAGES];
    logic [LINES-1:0] prev_q;

    assign raw_v = {sda_raw, scl_raw};

    // Synchroniser chain, one generate step per stage; idle bus is high.
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[s] <= '1;
                else        chain_q[s] <= raw_v;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[s] <= '1;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    // One-cycle-old copy of the synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= chain_q[STAGES-1];
    end

    // Edge and START/STOP pulses from current and previous levels.
    always_comb begin
        scl_lvl   = chain_q[STAGES-1][0];
        sda_lvl   = chain_q[STAGES-1][1];
        scl_rise  = scl_lvl && !prev_q[0];
        scl_fall  = !scl_lvl && prev_q[0];
        start_det = scl_lvl && prev_q[0] && prev_q[1] && !sda_lvl;
        stop_det  = scl_lvl && prev_q[0] && !prev_q[1] && sda_lvl;
    end

endmodule

// File: rtl/i2csel_engine.sv
// Module: i2csel_engine
// Target-side bit engine: receives the address and data bytes,
// acknowledges on a match, shifts the stored byte out on reads and
// follows the host acknowledge. Every change of sda_oe happens on an
// SCL falling edge, or on START/STOP where it can only go low.
// Assumes the pulses come from i2csel_sync.
module i2csel_engine
    import i2csel_pkg::*;
#(
    parameter logic [6:0] ADDR = 7'h70
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] stored,
    output logic       sda_oe,
    output logic       wr_stb,
    output logic [7:0] wr_data
);
    localparam int unsigned BYTE_BITS = 8;
    localparam int unsigned CNT_W     = $clog2(BYTE_BITS) + 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);

    eng_state_t     st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [7:0]     rx_q;
    logic [7:0]     tx_q;
    logic           rnw_q;
    logic           hack_q;
    logic           oe_q;
    logic           stb_q;

    // Protocol sequencing, bit counting, shifting and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            rx_q   <= '0;
            tx_q   <= '0;
            rnw_q  <= 1'b0;
            hack_q <= 1'b0;
            oe_q   <= 1'b0;
            stb_q  <= 1'b0;
        end else begin
            stb_q <= 1'b0;
            if (start_det) begin
                st_q  <= ST_ADDR;
                cnt_q <= '0;
                oe_q  <= 1'b0;
            end else if (stop_det) begin
                st_q  <= ST_IDLE;
                cnt_q <= '0;
                oe_q  <= 1'b0;
            end else begin
                case (st_q)
                    ST_ADDR, ST_WDATA: begin
                        if (scl_rise) begin
                            rx_q  <= {rx_q[6:0], sda_lvl};
                            cnt_q <= cnt_q + 1'b1;
                        end else if (scl_fall && cnt_q == FULL) begin
                            cnt_q <= '0;
                            if (st_q == ST_ADDR) begin
                                if (rx_q[7:1] == ADDR) begin
                                    oe_q  <= 1'b1;
                                    rnw_q <= rx_q[0];
                                    st_q  <= ST_AACK;
                                end else begin
                                    st_q <= ST_SKIP;
                                end
                            end else begin
                                stb_q <= 1'b1;
                                oe_q  <= 1'b1;
                                st_q  <= ST_WACK;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            cnt_q <= '0;
                            if (rnw_q) begin
                                tx_q <= stored;
                                oe_q <= ~stored[7];
                                st_q <= ST_RDATA;
                            end else begin
                                oe_q <= 1'b0;
                                st_q <= ST_WDATA;
                            end
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            cnt_q <= '0;
                            oe_q  <= 1'b0;
                            st_q  <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            cnt_q <= cnt_q + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt_q == FULL) begin
                                oe_q <= 1'b0;
                                st_q <= ST_RACK;
                            end else begin
                                tx_q <= {tx_q[6:0], 1'b0};
                                oe_q <= ~tx_q[6];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            hack_q <= ~sda_lvl;
                        end else if (scl_fall) begin
                            cnt_q <= '0;
                            if (hack_q) begin
                                tx_q <= stored;
                                oe_q <= ~stored[7];
                                st_q <= ST_RDATA;
                            end else begin
                                oe_q <= 1'b0;
                                st_q <= ST_SKIP;
                            end
                        end
                    end
                    default: begin
                        oe_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign sda_oe  = oe_q;
    assign wr_stb  = stb_q;
    assign wr_data = rx_q;

endmodule

// File: rtl/i2csel_select.sv
// Module: i2csel_select
// Holds the stored selection byte and the selection actually applied
// to the switches. A write updates the stored byte at once; the
// applied copy follows only on STOP, and only if a write is pending.
module i2csel_select
    import i2csel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic [7:0] wr_data,
    input  logic       stop_det,
    output logic [7:0] stored,
    output logic [1:0] chan_en
);
    logic [7:0] store_q;
    logic [7:0] live_q;
    logic       pend_q;

    // Stored byte: the last byte written wins.
    always_ff @(posedge clk) begin
        if (!rst_n)      store_q <= '0;
        else if (wr_stb) store_q <= wr_data;
    end

    // Pending flag and applied copy, transferred on STOP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            live_q <= '0;
        end else if (stop_det && pend_q) begin
            pend_q <= 1'b0;
            live_q <= store_q;
        end else if (wr_stb) begin
            pend_q <= 1'b1;
        end
    end

    assign stored  = store_q;
    assign chan_en = sel_to_enable(live_q);

endmodule

// File: rtl/i2csel_top.sv
// Module: i2csel_top
// I2C target that programs a two-way bus selector. Oversampled SCL/SDA
// in, open-drain SDA enable and two switch enables out. Assumes clk is
// at least 16x the SCL rate and that SCL is never stretched.
module i2csel_top #(
    parameter logic [6:0]  ADDR        = 7'h70,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [1:0] chan_en
);
    logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic       wr_stb;
    logic [7:0] wr_data;
    logic [7:0] stored;

    i2csel_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_raw  (scl_i),
        .sda_raw  (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2csel_engine #(.ADDR(ADDR)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .stored   (stored),
        .sda_oe   (sda_oe),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data)
    );

    i2csel_select u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .stop_det(stop_det),
        .stored  (stored),
        .chan_en (chan_en)
    );

endmodule

// File: rtl/i2csel_checker.sv
// Module: i2csel_checker
// Port-level properties of the selector, bound into i2csel_top.
// Keeps its own one-cycle copy of the raw lines to spot STOP/START.
module i2csel_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_i,
    input logic       sda_oe,
    input logic [1:0] chan_en
);
    logic sda_d;
    logic scl_d;
    logic stop_seen;

    // Raw-line history and a flag that a STOP came after the last START.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_d     <= 1'b1;
            scl_d     <= 1'b1;
            stop_seen <= 1'b0;
        end else begin
            sda_d <= sda_i;
            scl_d <= scl_i;
            if (scl_i && scl_d && !sda_d && sda_i)      stop_seen <= 1'b1;
            else if (scl_i && scl_d && sda_d && !sda_i) stop_seen <= 1'b0;
        end
    end

    a_r1_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_en));

    a_r3_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (chan_en == 2'b00 && !sda_oe));

    a_r4_apply_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en != $past(chan_en)) |-> stop_seen);

    a_r7_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

endmodule

bind i2csel_top i2csel_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .sda_oe (sda_oe),
    .chan_en(chan_en)
);

// File: tb/test_i2csel_top.sv
module test_i2csel_top;
    localparam logic [6:0] DUT_ADDR = 7'h70;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [1:0] chan_en;
    logic       sda_line;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    i2csel_top #(.ADDR(DUT_ADDR)) i_i2csel_top (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_m),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .chan_en(chan_en)
    );

    // Expected enable pair from a selection byte (R2).
    function automatic logic [1:0] exp_en(input logic [7:0] b);
        if (b[2] == 1'b0) return 2'b00;
        if (b[1] == 1'b1) return 2'b00;
        return b[0] ? 2'b10 : 2'b01;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b1; hold(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    hold(Q);
        scl_m = 1'b1; hold(2 * Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        b = sda_line; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        acked = ~a;
    endtask

    task automatic get_byte(input logic host_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~host_ack);
    endtask

    // Read nb bytes, checking each equals exp (R6) and release after NACK (R8).
    task automatic read_check(input int nb, input logic [7:0] exp, input string tag);
        logic a;
        logic [7:0] v;
        put_byte({DUT_ADDR, 1'b1}, a);
        chk(a, {tag, " R7 read address ack"}, a, 1);
        for (int k = 0; k < nb; k++) begin
            get_byte(k != nb - 1, v);
            chk(v == exp, {tag, " R6 read data"}, v, exp);
        end
        chk(sda_oe == 1'b0, {tag, " R8 released after nack"}, sda_oe, 0);
    endtask

    initial begin
        logic a;
        logic [7:0] last, applied, v;
        int nb;
        void'($urandom(32'h5EED));
        hold(5);
        rst_n = 1'b1;
        hold(3);
        chk(chan_en == 2'b00, "R3 reset chan_en", chan_en, 0);
        chk(sda_oe == 1'b0, "R3 reset sda_oe", sda_oe, 0);
        bus_start();
        read_check(1, 8'h00, "R3 reset byte");
        bus_stop();

        // Directed: write 0x04, held until STOP.
        bus_start();
        put_byte({DUT_ADDR, 1'b0}, a);
        chk(a, "R7 write address ack", a, 1);
        put_byte(8'h04, a);
        chk(a, "R7 data ack", a, 1);
        hold(4 * Q);
        chk(chan_en == 2'b00, "R4 not applied before stop", chan_en, 0);
        bus_stop(); hold(Q);
        chk(chan_en == 2'b01, "R2 channel 0", chan_en, 1);

        // Multi-byte write keeps last (R5), 0x0D decodes to channel 1.
        bus_start();
        put_byte({DUT_ADDR, 1'b0}, a);
        put_byte(8'h05, a);
        put_byte(8'h06, a);
        put_byte(8'h0D, a);
        chk(a, "R7 third data ack", a, 1);
        bus_stop(); hold(Q);
        chk(chan_en == 2'b10, "R5 last byte applied", chan_en, 2);

        // Repeated START into a read does not apply (R4, R10).
        bus_start();
        put_byte({DUT_ADDR, 1'b0}, a);
        put_byte(8'hF4, a);
        bus_start();
        chk(chan_en == 2'b10, "R10 repeated start no apply", chan_en, 2);
        read_check(2, 8'hF4, "R4 pending");
        chk(chan_en == 2'b10, "R4 still old before stop", chan_en, 2);
        bus_stop(); hold(Q);
        chk(chan_en == 2'b01, "R4 applied at stop", chan_en, 1);

        // Non-matching address ignored (R9).
        bus_start();
        put_byte({DUT_ADDR ^ 7'h01, 1'b0}, a);
        chk(!a, "R9 no ack on mismatch", a, 0);
        put_byte(8'h05, a);
        chk(!a, "R9 data ignored", a, 0);
        bus_stop(); hold(Q);
        chk(chan_en == 2'b01, "R9 selection unchanged", chan_en, 1);
        bus_start();
        read_check(1, 8'hF4, "R9 byte unchanged");
        bus_stop();

        // Bits[2:1]=11 and bit2=0 deselect (R2).
        bus_start(); put_byte({DUT_ADDR, 1'b0}, a); put_byte(8'h07, a); bus_stop(); hold(Q);
        chk(chan_en == 2'b00, "R2 code 11x deselects", chan_en, 0);
        bus_start(); put_byte({DUT_ADDR, 1'b0}, a); put_byte(8'hFB, a); bus_stop(); hold(Q);
        chk(chan_en == 2'b00, "R2 bit2 low deselects", chan_en, 0);
        applied = 8'hFB;

        // Random multi-byte writes with read-back.
        for (int it = 0; it < 24; it++) begin
            nb = 1 + ($urandom % 3);
            bus_start();
            put_byte({DUT_ADDR, 1'b0}, a);
            chk(a, "R7 random address ack", a, 1);
            for (int k = 0; k < nb; k++) begin
                last = 8'($urandom);
                put_byte(last, a);
                chk(a, "R7 random data ack", a, 1);
            end
            chk(chan_en == exp_en(applied), "R4 random hold", chan_en, exp_en(applied));
            bus_stop(); hold(Q);
            applied = last;
            chk(chan_en == exp_en(last), "R2 R5 random apply", chan_en, exp_en(last));
            bus_start();
            read_check(1 + ($urandom % 2), last, "R6 random");
            bus_stop();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule